// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned W-bit operands and produces their 2W-bit product. It handles one multiplier bit per clock and keeps only one double-width working register. When an operand pair is accepted, the upper half of that register is cleared and the multiplier is placed in the lower half. On each step the bit at position 0 chooses the action. If it is 1, the multiplicand is added to the upper half, and the sum together with its carry is shifted right by one bit across the whole register. If it is 0, the register is only shifted right. After W steps the register holds the complete product.

Operands enter through a valid/ready handshake. `op_ready` is high while the block is idle or is holding a finished result, and a pair is taken on any clock edge where `op_valid` and `op_ready` are both high. While a multiplication runs, `op_ready` is low and `op_valid` has no effect, so a source has to hold its pair until `op_ready` returns. The result side has no back-pressure: `done` rises after the last step, and both `done` and `product` stay fixed until the next pair is accepted. The default width is 8 bits, and the block also works with a width of 4.

Top module: `seq_shift_add_mult`

## Requirements
- R1: While `rst` is high at a clock edge (synchronous, active high), the block goes idle: after that edge `done` is 0, `op_ready` is 1 and `product` is 0. This applies even when a multiplication is running.
- R2: On an edge with `op_valid` and `op_ready` both high, the block takes the pair. After that edge, `product` equals the multiplier zero-extended (upper W bits zero, lower W bits = `multiplier`), and both `op_ready` and `done` are 0.
- R3: During a step where `product[0]` is 1, the multiplicand is added to `product[2W-1:W]`. The (W+1)-bit sum, with its carry as the new bit 2W-1, is shifted right together with the lower half. For 4-bit operands 13 × 11, `product` after each step is 0x6D, 0x9E, (step 3), 0x8F.
- R4: During a step where `product[0]` is 0, `product` becomes its previous value shifted right by one bit with a 0 shifted in at the top. In the 13 × 11 case, step 3 takes 0x9E to 0x4F.
- R5: Exactly W steps are performed. `done` rises on the W-th edge after the accepting edge, `op_ready` is 0 until then, and `done` is never high while `op_ready` is low.
- R6: When `done` is high, `product` equals `multiplicand` × `multiplier` as unsigned numbers, including the all-ones case.
- R7: If either operand is zero, the final product is zero.
- R8: While a multiplication runs (`op_ready` low), a high `op_valid` with any operand values does not change the result or the step count.
- R9: While `done` is high and no pair is accepted, `done` stays 1 and `product` does not change. After the next accepting edge, `done` is 0.
- R10: With W = 4, every one of the 256 operand pairs gives the correct 8-bit product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | An operand pair is offered |
| op_ready | output | 1 | Block can accept a pair (idle or holding a result) |
| multiplicand | input | W | Value added into the upper half on each 1 bit |
| multiplier | input | W | Value scanned from bit 0 upward |
| done | output | 1 | Product complete and held |
| product | output | 2W | Working register; the full product when `done` is high |

## Verification
`product` shows the loaded multiplier one edge after acceptance. Each later edge shows one more step, and `done` together with the final product follows W edges after acceptance. The reference model in the bench counts these edges from the accepting edge and compares `op_ready`, `done` and, where it is defined, `product` at every falling edge, which is half a period after the register updates. For the 13 × 11 case, the value after each step is compared with a stored trajectory. Reset is checked one edge after it is sampled.

// File: rtl/ssam_pkg.sv
package ssam_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } ssam_state_e;
endpackage

// File: rtl/ssam_step.sv
// One add-or-shift step on the combined accumulator/multiplier register.
module ssam_step #(
  parameter int W = 8
) (
  input  logic [2*W-1:0] acc,
  input  logic [W-1:0]   mcand,
  output logic [2*W-1:0] acc_next
);
  localparam int AW = W + 1;

  logic [AW-1:0] addend;
  logic [AW-1:0] upper_sum;

  always_comb begin
    addend    = acc[0] ? {1'b0, mcand} : '0;
    upper_sum = {1'b0, acc[2*W-1:W]} + addend;
    // carry lands in the top bit, lower half moves down one place
    acc_next  = {upper_sum, acc[W-1:1]};
  end
endmodule

// File: rtl/ssam_counter.sv
// Counts completed steps; flags the final one.
module ssam_counter #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  output logic last
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (step)    cnt <= cnt + 1'b1;
  end

  assign last = step && (cnt == LAST_IDX);
endmodule

// File: rtl/ssam_ctrl.sv
// Sequencer: accept, run W steps, hold result.
module ssam_ctrl
  import ssam_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic op_valid,
  input  logic last,
  output logic op_ready,
  output logic done,
  output logic load,
  output logic step
);
  ssam_state_e state, state_nx;

  always_comb begin
    op_ready = (state != ST_RUN);
    load     = op_valid && op_ready;
    step     = (state == ST_RUN);
    done     = (state == ST_HOLD);
    state_nx = state;
    unique case (state)
      ST_IDLE: if (load) state_nx = ST_RUN;
      ST_RUN:  if (last) state_nx = ST_HOLD;
      ST_HOLD: if (load) state_nx = ST_RUN;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nx;
  end
endmodule

// File: rtl/seq_shift_add_mult.sv
module seq_shift_add_mult #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           op_valid,
  output logic           op_ready,
  input  logic [W-1:0]   multiplicand,
  input  logic [W-1:0]   multiplier,
  output logic           done,
  output logic [2*W-1:0] product
);
  localparam int PW = 2 * W;

  logic          load, step, last;
  logic [W-1:0]  mcand_q;
  logic [PW-1:0] acc_q, acc_nx;

  ssam_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .last     (last),
    .op_ready (op_ready),
    .done     (done),
    .load     (load),
    .step     (step)
  );

  ssam_counter #(.W(W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clear (load),
    .step  (step),
    .last  (last)
  );

  ssam_step #(.W(W)) u_step (
    .acc      (acc_q),
    .mcand    (mcand_q),
    .acc_next (acc_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      mcand_q <= '0;
    end else if (load) begin
      acc_q   <= {{W{1'b0}}, multiplier};
      mcand_q <= multiplicand;
    end else if (step) begin
      acc_q   <= acc_nx;
    end
  end

  assign product = acc_q;
endmodule

// File: rtl/ssam_checker.sv
module ssam_checker #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           op_valid,
  input logic           op_ready,
  input logic [W-1:0]   multiplier,
  input logic           done,
  input logic [2*W-1:0] product
);
  int unsigned cyc;

  always_ff @(posedge clk) begin
    if (rst || (op_valid && op_ready)) cyc <= 0;
    else if (!op_ready)                cyc <= cyc + 1;
  end

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_ready) |=>
      (product == {{W{1'b0}}, $past(multiplier)}) && !done && !op_ready);

  p_low_shift_r3: assert property (@(posedge clk) disable iff (rst)
    (!op_ready && product[0]) |=> (product[W-2:0] == $past(product[W-1:1])));

  p_shift_only_r4: assert property (@(posedge clk) disable iff (rst)
    (!op_ready && !product[0]) |=> (product == ($past(product) >> 1)));

  p_done_ready_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> op_ready);

  p_step_count_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (cyc == W));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (done && !op_valid) |=> (done && $stable(product)));
endmodule

bind seq_shift_add_mult ssam_checker #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .op_valid   (op_valid),
  .op_ready   (op_ready),
  .multiplier (multiplier),
  .done       (done),
  .product    (product)
);

// File: tb/seq_shift_add_mult_test.sv
`timescale 1ns/1ps
module seq_shift_add_mult_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        v8 = 0, rdy8, done8;
  logic [7:0]  a8 = 0, b8 = 0;
  logic [15:0] p8;
  logic        v4 = 0, rdy4, done4;
  logic [3:0]  a4 = 0, b4 = 0;
  logic [7:0]  p4;

  int n_run = 0, n_fail = 0;

  seq_shift_add_mult #(.W(8)) uut (
    .clk(clk), .rst(rst), .op_valid(v8), .op_ready(rdy8),
    .multiplicand(a8), .multiplier(b8), .done(done8), .product(p8));

  seq_shift_add_mult #(.W(4)) uut_w4 (
    .clk(clk), .rst(rst), .op_valid(v4), .op_ready(rdy4),
    .multiplicand(a4), .multiplier(b4), .done(done4), .product(p4));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int prod_of(input int w);
    return (w == 8) ? int'(p8) : int'(p4);
  endfunction
  function automatic int done_of(input int w);
    return (w == 8) ? int'(done8) : int'(done4);
  endfunction
  function automatic int rdy_of(input int w);
    return (w == 8) ? int'(rdy8) : int'(rdy4);
  endfunction

  task automatic drive(input int w, input bit v, input int a, input int b);
    if (w == 8) begin v8 = v; a8 = a[7:0]; b8 = b[7:0]; end
    else        begin v4 = v; a4 = a[3:0]; b4 = b[3:0]; end
  endtask

  // Reference model: counts edges from acceptance, compares every falling edge.
  task automatic run_op(input int w, input int a, input int b, input bit poke);
    int exp_p;
    exp_p = a * b;
    @(negedge clk);
    chk(rdy_of(w) == 1, "R2 ready before accept", rdy_of(w), 1);
    drive(w, 1, a, b);
    @(negedge clk);
    drive(w, 0, 0, 0);
    chk(prod_of(w) == b, "R2 loaded multiplier", prod_of(w), b);
    chk(done_of(w) == 0, "R9 done drops on accept", done_of(w), 0);
    for (int s = 1; s <= w; s++) begin
      if (poke && s == 2) drive(w, 1, (1 << w) - 1, (1 << w) - 1);
      @(negedge clk);
      drive(w, 0, 0, 0);
      if (s < w) begin
        chk(done_of(w) == 0 && rdy_of(w) == 0, "R5 busy during steps",
            done_of(w) * 2 + rdy_of(w), 0);
      end else begin
        chk(done_of(w) == 1 && rdy_of(w) == 1, "R5 done after W steps",
            done_of(w) * 2 + rdy_of(w), 3);
        chk(prod_of(w) == exp_p,
            (a == 0 || b == 0) ? "R7 zero operand" :
            (w == 4) ? "R10 4-bit pair" : (poke ? "R8 busy request ignored" : "R6 product"),
            prod_of(w), exp_p);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int traj[5];
    traj = '{8'h0B, 8'h6D, 8'h9E, 8'h4F, 8'h8F};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(done8 == 0 && rdy8 == 1 && p8 == 0, "R1 reset state w8", {done8, rdy8, p8}, 32'h10000);
    chk(done4 == 0 && rdy4 == 1 && p4 == 0, "R1 reset state w4", {done4, rdy4, p4}, 32'h100);

    // R3/R4 worked 4-bit trajectory 13 x 11
    drive(4, 1, 13, 11);
    @(negedge clk);
    drive(4, 0, 0, 0);
    chk(p4 == traj[0], "R2 trajectory load", p4, traj[0]);
    for (int s = 1; s <= 4; s++) begin
      @(negedge clk);
      chk(p4 == traj[s], (s == 3) ? "R4 shift-only step" : "R3 add-shift step", p4, traj[s]);
    end
    chk(done4 == 1, "R5 done 13x11", done4, 1);

    // R9 hold
    repeat (3) begin
      @(negedge clk);
      chk(done4 == 1 && p4 == 8'h8F, "R9 result held", p4, 8'h8F);
    end

    // directed 8-bit corner cases
    run_op(8, 255, 255, 0);
    run_op(8, 0, 37, 0);
    run_op(8, 37, 0, 0);
    run_op(8, 1, 1, 0);
    run_op(8, 128, 2, 0);
    run_op(8, 200, 3, 1);
    run_op(8, 13, 11, 1);

    // random 8-bit pairs
    for (int i = 0; i < 60; i++) run_op(8, $urandom_range(255), $urandom_range(255), i[0]);

    // exhaustive 4-bit
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        run_op(4, a, b, 0);

    // R1 reset in the middle of a run
    @(negedge clk);
    drive(8, 1, 99, 77);
    @(negedge clk);
    drive(8, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk(done8 == 0 && rdy8 == 1 && p8 == 0, "R1 reset mid-run", {done8, rdy8, p8}, 32'h10000);
    run_op(8, 99, 77, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule